// File: doc/BRIEF.md
# ATA Drive-Position Reset and Self-Diagnosis Sequencer

This block sits on the device side of one ATA drive position. It runs the power-on and software-reset sequences of that position. The sequences cover the self-diagnosis and the handshake between the two positions on a cable. On one line, the second drive announces that it is present. On the other, it reports that it passed its diagnosis. The first drive listens to both lines. If the second drive never reports a pass, the first drive marks the failure in the top bit of its own diagnostic code. After every completed diagnosis the block loads the reset signature into the task-file values. The host's EXECUTE DIAGNOSTIC command reuses the same path.

Every phase is timed by one busy counter. The state register doubles as the counter's purpose tag, so the state in force decides what happens when the count runs out. The states are:

- `SEQ_BOOT`: the single cycle after hardware reset, which branches on the position bit.
- `SEQ_DETECT`: position 0 watches for the other drive.
- `SEQ_DIAG`: the diagnostic delay.
- `SEQ_PDIAG_WAIT`: position 0 waits for the pass report from position 1.
- `SEQ_SRST_HOLD`: busy is held, with no timeout, while the software-reset bit is set.
- `SEQ_IDLE`

The transitions are:

- BOOT→DETECT when the position bit is 0.
- BOOT→DIAG when the position bit is 1.
- DETECT→DIAG on expiry.
- DIAG→PDIAG_WAIT on expiry, for a paired position 0 that has not yet seen the pass report.
- DIAG→IDLE otherwise.
- PDIAG_WAIT→IDLE when the pass report arrives or on expiry.
- any state→SRST_HOLD on an accepted rising software-reset bit.
- SRST_HOLD→DIAG when that bit clears.
- IDLE→DIAG on a diagnostic command.

Top module: `ata_rst_diag_seq`

## Requirements
- R1: While hardware reset is applied, `busy_o`=1, `dasp_o`=0, `pdiag_o`=0, `irq_o`=0, `err_o`=0x00, all five signature outputs are 0, and `single_o`=0.
- R2: Position 0 stays busy for DET_CYC cycles of presence detection and then DIAG_CYC cycles of diagnosis. `single_o` becomes 1 only if `dasp_i` was low throughout the detection window.
- R3: Position 1 drives `dasp_o`=1 from the first clock after reset and skips the detection window. It is busy for DIAG_CYC cycles.
- R4: Diagnosis loads `err_o`=0x01 when `present_i`=1 and 0x00 when `present_i`=0.
- R5: Position 1 drives `pdiag_o`=1 after a passing diagnosis and never after a failing one.
- R6: A paired position 0 (`single_o`=0) that sees `pdiag_i`=0 at the end of its diagnosis stays busy for up to PDIAG_CYC more cycles. If the wait runs out, bit 7 of `err_o` is set (0x81 for a present drive).
- R7: `pdiag_i`=1 during that wait ends it on the next clock without setting bit 7. If `pdiag_i` is already 1 when the diagnosis ends, no wait takes place.
- R8: Completing a diagnosis loads sector count=1, sector number=1, cylinder low=0, cylinder high=0 and device/head=0, and drops `busy_o`.
- R9: A rising `srst_i` while a hardware-reset sequence is in progress has no effect on the sequence or its length.
- R10: Outside that window, a rising `srst_i` clears `dasp_o`, `pdiag_o` and `irq_o` and holds `busy_o`=1 for as long as `srst_i` stays high. When `srst_i` falls, a DIAG_CYC diagnosis follows.
- R11: A one-cycle `exec_diag_i` pulse while idle runs a DIAG_CYC diagnosis. On completion, `irq_o` rises on position 0 only.
- R12: `exec_diag_i` is ignored while `busy_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| pos_i | input | 1 | Drive position: 0 = first drive, 1 = second drive |
| present_i | input | 1 | Media present; decides pass or fail |
| dasp_i | input | 1 | Incoming presence line from the other drive |
| pdiag_i | input | 1 | Incoming pass report from the other drive |
| srst_i | input | 1 | Software-reset bit of the device-control value |
| exec_diag_i | input | 1 | One-cycle EXECUTE DIAGNOSTIC trigger |
| dasp_o | output | 1 | Outgoing presence line |
| pdiag_o | output | 1 | Outgoing pass report |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | BSY status bit |
| single_o | output | 1 | No second drive was detected |
| err_o | output | 8 | Diagnostic code |
| sec_cnt_o | output | 8 | Sector count signature |
| sec_num_o | output | 8 | Sector number signature |
| cyl_lo_o | output | 8 | Cylinder low signature |
| cyl_hi_o | output | 8 | Cylinder high signature |
| dev_head_o | output | 8 | Device/head signature |

## Verification
The hardest situation to reach is the pass report arriving in the middle of the wait for position 1. The stimulus counts falling edges from the release of reset, with the presence line held high. It raises `pdiag_i` at a known cycle inside the wait. The busy length must then end exactly one clock later, and the code must stay 0x01. A second corner is a software reset that arrives during hardware reset. The stimulus pulses `srst_i` inside the detection window and checks that the busy length is unchanged. A diagnostic command issued during the held software reset must leave `irq_o` low afterwards.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
    // The state doubles as the purpose tag of the single busy timer.
    typedef enum logic [2:0] {
        SEQ_BOOT,
        SEQ_DETECT,
        SEQ_DIAG,
        SEQ_PDIAG_WAIT,
        SEQ_SRST_HOLD,
        SEQ_IDLE
    } seq_state_e;

    localparam logic [7:0] DIAG_PASS = 8'h01;
    localparam logic [7:0] DIAG_FAIL = 8'h00;
endpackage

// File: rtl/ata_seq_busy_timer.sv
module ata_seq_busy_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/ata_rst_diag_seq.sv
module ata_rst_diag_seq
    import ata_seq_pkg::*;
#(
    parameter int unsigned DET_CYC   = 400000,
    parameter int unsigned DIAG_CYC  = 400000,
    parameter int unsigned PDIAG_CYC = 400000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pos_i,
    input  logic       present_i,
    input  logic       dasp_i,
    input  logic       pdiag_i,
    input  logic       srst_i,
    input  logic       exec_diag_i,
    output logic       dasp_o,
    output logic       pdiag_o,
    output logic       irq_o,
    output logic       busy_o,
    output logic       single_o,
    output logic [7:0] err_o,
    output logic [7:0] sec_cnt_o,
    output logic [7:0] sec_num_o,
    output logic [7:0] cyl_lo_o,
    output logic [7:0] cyl_hi_o,
    output logic [7:0] dev_head_o
);
    localparam int unsigned MAX_A   = (DET_CYC > DIAG_CYC) ? DET_CYC : DIAG_CYC;
    localparam int unsigned MAX_CYC = (MAX_A > PDIAG_CYC) ? MAX_A : PDIAG_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_e       state_q, state_d;
    logic             expire, tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             srst_q, resetting_q, seen_q, cmd_q;
    logic             srst_take, diag_done, wait_fail, finish;

    assign srst_take = srst_i && !srst_q && !resetting_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_BOOT:       state_d = pos_i ? SEQ_DIAG : SEQ_DETECT;
            SEQ_DETECT:     if (expire) state_d = SEQ_DIAG;
            SEQ_DIAG:       if (expire)
                                state_d = (!pos_i && !single_o && !pdiag_i)
                                          ? SEQ_PDIAG_WAIT : SEQ_IDLE;
            SEQ_PDIAG_WAIT: if (pdiag_i || expire) state_d = SEQ_IDLE;
            SEQ_SRST_HOLD:  if (!srst_i) state_d = SEQ_DIAG;
            SEQ_IDLE:       if (exec_diag_i) state_d = SEQ_DIAG;
            default:        state_d = SEQ_IDLE;
        endcase
        if (srst_take) state_d = SEQ_SRST_HOLD;
    end

    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            SEQ_DETECT:     tmr_val = CNT_W'(DET_CYC - 1);
            SEQ_DIAG:       tmr_val = CNT_W'(DIAG_CYC - 1);
            SEQ_PDIAG_WAIT: tmr_val = CNT_W'(PDIAG_CYC - 1);
            default: begin
                tmr_val  = '0;
                tmr_load = 1'b0;
            end
        endcase
    end

    assign diag_done = (state_q == SEQ_DIAG) && expire && !srst_take;
    assign wait_fail = (state_q == SEQ_PDIAG_WAIT) && expire && !pdiag_i && !srst_take;
    assign finish    = (state_q == SEQ_DIAG || state_q == SEQ_PDIAG_WAIT)
                       && (state_d == SEQ_IDLE);
    assign busy_o    = (state_q != SEQ_IDLE);

    ata_seq_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (expire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_BOOT;
        else        state_q <= state_d;
    end

    // Output and flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dasp_o <= 1'b0; pdiag_o <= 1'b0; irq_o <= 1'b0;
            single_o <= 1'b0; err_o <= '0;
            sec_cnt_o <= '0; sec_num_o <= '0; cyl_lo_o <= '0;
            cyl_hi_o <= '0; dev_head_o <= '0;
            srst_q <= 1'b0; resetting_q <= 1'b1; seen_q <= 1'b0; cmd_q <= 1'b0;
        end else begin
            srst_q <= srst_i;
            if (state_q == SEQ_BOOT && pos_i) dasp_o <= 1'b1;
            if (state_q == SEQ_DETECT) begin
                seen_q <= seen_q | dasp_i;
                if (expire) single_o <= !(seen_q | dasp_i);
            end
            if (srst_take) begin
                dasp_o <= 1'b0; pdiag_o <= 1'b0; irq_o <= 1'b0;
            end
            if (diag_done) begin
                err_o <= present_i ? DIAG_PASS : DIAG_FAIL;
                if (pos_i && present_i) pdiag_o <= 1'b1;
            end
            if (wait_fail) err_o[7] <= 1'b1;
            if (finish) begin
                sec_cnt_o <= 8'd1; sec_num_o <= 8'd1;
                cyl_lo_o <= 8'd0; cyl_hi_o <= 8'd0; dev_head_o <= 8'd0;
                resetting_q <= 1'b0;
                cmd_q <= 1'b0;
                if (cmd_q && !pos_i) irq_o <= 1'b1;
            end
            if (state_q == SEQ_IDLE && exec_diag_i && !srst_take) begin
                cmd_q <= 1'b1;
                irq_o <= 1'b0;
            end
            if (state_q == SEQ_SRST_HOLD && !srst_i) cmd_q <= 1'b0;
        end
    end

    // Assertions
    p_single_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEQ_DETECT) |=> $stable(single_o));
    p_pdiag_on_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pdiag_o) |-> (pos_i && err_o == DIAG_PASS));
    p_bit7_from_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o[7]) |-> $past(state_q == SEQ_PDIAG_WAIT));
    p_finish_signature_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(resetting_q) |-> (sec_cnt_o == 8'd1 && sec_num_o == 8'd1 && !busy_o));
    p_srst_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resetting_q && srst_i && !srst_q) |=> (state_q != SEQ_SRST_HOLD));
    p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_SRST_HOLD && srst_i) |=> busy_o);
    p_irq_dev0_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (!pos_i && !busy_o));
endmodule

// File: tb/tb_ata_rst_diag_seq.sv
`timescale 1ns/1ps
module tb_ata_rst_diag_seq;
    localparam int DET = 8, DIAG = 6, PW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pos = 0, present = 1, dasp_in = 0, pdiag_in = 0, srst = 0, exec_d = 0;
    logic dasp_o, pdiag_o, irq_o, busy_o, single_o;
    logic [7:0] err_o, sc, sn, cl, ch, dh;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    ata_rst_diag_seq #(.DET_CYC(DET), .DIAG_CYC(DIAG), .PDIAG_CYC(PW)) dut (
        .clk(clk), .rst_n(rst_n), .pos_i(pos), .present_i(present),
        .dasp_i(dasp_in), .pdiag_i(pdiag_in), .srst_i(srst), .exec_diag_i(exec_d),
        .dasp_o(dasp_o), .pdiag_o(pdiag_o), .irq_o(irq_o), .busy_o(busy_o),
        .single_o(single_o), .err_o(err_o), .sec_cnt_o(sc), .sec_num_o(sn),
        .cyl_lo_o(cl), .cyl_hi_o(ch), .dev_head_o(dh));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hw_reset(input logic p, input logic pr, input logic da, input logic pd);
        rst_n = 1'b0;
        pos = p; present = pr; dasp_in = da; pdiag_in = pd; srst = 0; exec_d = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Counts falling edges with busy high, starting from n0.
    task automatic measure(input int n0, output int n);
        n = n0;
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (!busy_o) break;
            n++;
        end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "busy", busy_o, 1);
        chk("R1", "dasp", dasp_o, 0);
        chk("R1", "pdiag", pdiag_o, 0);
        chk("R1", "irq", irq_o, 0);
        chk("R1", "err", err_o, 0);
        chk("R1", "sec_cnt", sc, 0);
        chk("R1", "single", single_o, 0);
    endtask

    task automatic t_dev0_single();
        int n;
        hw_reset(0, 1, 0, 0);
        measure(0, n);
        chk("R2", "dev0 busy cycles", n, DET + DIAG);
        chk("R2", "single", single_o, 1);
        chk("R4", "pass code", err_o, 8'h01);
        chk("R8", "sec_cnt", sc, 1);
        chk("R8", "sec_num", sn, 1);
        chk("R8", "cyl/devhead", {cl, ch, dh}, 0);
        chk("R11", "no irq on reset", irq_o, 0);
    endtask

    task automatic t_dev1(input logic pr);
        int n;
        hw_reset(1, pr, 0, 0);
        @(negedge clk);
        chk("R3", "dasp after first clock", dasp_o, 1);
        measure(1, n);
        chk("R3", "dev1 busy cycles", n, DIAG);
        chk("R4", "code", err_o, pr ? 8'h01 : 8'h00);
        chk("R5", "pdiag out", pdiag_o, pr);
    endtask

    task automatic t_pair_timeout();
        int n;
        hw_reset(0, 1, 1, 0);
        measure(0, n);
        chk("R6", "busy with wait", n, DET + DIAG + PW);
        chk("R6", "not single", single_o, 0);
        chk("R6", "bit7 code", err_o, 8'h81);
    endtask

    task automatic t_pair_midwait();
        int n = 0;
        hw_reset(0, 1, 1, 0);
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (!busy_o) break;
            n++;
            if (n == DET + DIAG + 3) pdiag_in = 1'b1;
        end
        chk("R7", "early end of wait", n, DET + DIAG + 3);
        chk("R7", "code without bit7", err_o, 8'h01);
    endtask

    task automatic t_pair_preset();
        int n;
        hw_reset(0, 1, 1, 1);
        measure(0, n);
        chk("R7", "no wait when pdiag high", n, DET + DIAG);
        chk("R7", "code", err_o, 8'h01);
    endtask

    task automatic t_srst_during_reset();
        int n;
        hw_reset(0, 1, 0, 0);
        repeat (3) @(negedge clk);
        srst = 1;
        repeat (2) @(negedge clk);
        srst = 0;
        measure(5, n);
        chk("R9", "length unchanged", n, DET + DIAG);
    endtask

    task automatic t_srst_idle();
        int n;
        logic held = 1'b1;
        hw_reset(1, 1, 0, 0);
        measure(0, n);
        srst = 1;
        @(negedge clk);
        chk("R10", "busy on srst", busy_o, 1);
        chk("R10", "dasp cleared", dasp_o, 0);
        chk("R10", "pdiag cleared", pdiag_o, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            held &= busy_o;
        end
        chk("R10", "held busy without timeout", held, 1);
        srst = 0;
        measure(0, n);
        chk("R10", "diag after release", n, DIAG);
        chk("R5", "pdiag after soft reset", pdiag_o, 1);
        chk("R8", "signature after soft reset", sc, 1);
    endtask

    task automatic t_exec(input logic p);
        int n;
        hw_reset(p, 1, 0, 0);
        measure(0, n);
        exec_d = 1;
        @(negedge clk);
        exec_d = 0;
        measure(1, n);
        chk("R11", "command diag cycles", n, DIAG);
        chk("R11", "irq on completion", irq_o, !p);
    endtask

    task automatic t_exec_busy();
        int n;
        hw_reset(0, 1, 0, 0);
        repeat (4) @(negedge clk);
        exec_d = 1;
        @(negedge clk);
        exec_d = 0;
        measure(5, n);
        chk("R12", "length unchanged", n, DET + DIAG);
        chk("R12", "irq stays low", irq_o, 0);
        srst = 1;
        repeat (3) @(negedge clk);
        exec_d = 1;
        @(negedge clk);
        exec_d = 0;
        srst = 0;
        measure(0, n);
        chk("R12", "irq low after hold", irq_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_dev0_single();
        t_dev1(1'b1);
        t_dev1(1'b0);
        t_pair_timeout();
        t_pair_midwait();
        t_pair_preset();
        t_srst_during_reset();
        t_srst_idle();
        t_exec(1'b0);
        t_exec(1'b1);
        t_exec_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule